// File: doc/BRIEF.md
# Configurable Multiplexed I/O Cell

This block is one programmable pin cell of a crossbar-style interconnect. A 4:1 routing multiplexer picks one of four source buses. The chosen word can pass straight through, go through an edge-triggered register with a clock enable, or go through a level-sensitive latch. It then passes a programmable inverter and reaches a pad driver. The driver works either as a plain three-state buffer or in open-drain fashion. The raw multiplexer result is also presented on a tap that a neighbouring cell can route. A second holding element, with the same three choices, captures the value arriving from the pad for bidirectional use.

All mode choices come from static configuration pins. The cell copies these pins into an internal configuration register only while the synchronous, active-high reset is asserted, and ignores them at every other time. The pad is modelled as three separate signals: drive value, per-bit drive enable and received value.

The latch is modelled synchronously. While its enable is high, the output follows the input without delay and the held word is refreshed at every rising clock edge. While the enable is low, the output shows the word held at the last rising edge at which the enable was high. Any source input can be forced to all ones, which stands in for an unused input.

Top module: `mux_io_cell`

## Requirements
- R1: `adj_out` equals `src0`, `src1`, `src2` or `src3` for `sel` = 0, 1, 2 or 3 (bit 0 of `sel` is the low select bit), with no clock delay.
- R2: When bit k of the stored tie-high mask is 1, source k reads as all ones wherever it is selected.
- R3: With output mode 2'b01 (register), the data word before inversion takes the multiplexer value at a rising edge where `ce` = 1, and keeps its value at a rising edge where `ce` = 0.
- R4: With output mode 2'b10 (latch), the data word follows the multiplexer while `en` = 1. While `en` = 0 it holds the word captured at the last rising edge with `en` = 1.
- R5: With output mode 2'b00 or 2'b11 (bypass), the data word equals the multiplexer value in the same cycle.
- R6: When the stored invert bit is 1, every bit of the data word is complemented before the pad driver.
- R7: In three-state mode (open-drain bit 0), `pad_out` carries the data word and every bit of `pad_oe` equals `oe`, so `oe` = 0 releases the whole pad.
- R8: In open-drain mode, `pad_out` is always 0, and bit i of `pad_oe` is 1 exactly when `oe` = 1 and data bit i is 0.
- R9: `in_data` follows `pad_in` in input mode 2'b00/2'b11. It captures `pad_in` on a rising edge with `ce` = 1 in mode 2'b01, and behaves as the R4 latch on `pad_in` in mode 2'b10.
- R10: A rising edge with `rst` = 1 clears both holding elements to zero and loads the configuration pins. Configuration pins changed while `rst` = 0 have no effect.
- R11: `adj_out` does not depend on the storage mode, the inversion, the output stage or `oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; also loads configuration |
| cfg_out_mode | input | 2 | Output storage: 00/11 bypass, 01 register, 10 latch |
| cfg_in_mode | input | 2 | Input capture: 00/11 direct, 01 register, 10 latch |
| cfg_invert | input | 1 | Complement the output data word |
| cfg_open_drain | input | 1 | 1 selects open-drain, 0 selects three-state |
| cfg_tie_high | input | 4 | Bit k forces source k to all ones |
| src0 | input | W | Multiplexer source 0 |
| src1 | input | W | Multiplexer source 1 |
| src2 | input | W | Multiplexer source 2 |
| src3 | input | W | Multiplexer source 3 |
| sel | input | 2 | Multiplexer select, bit 0 low |
| ce | input | 1 | Register clock enable |
| en | input | 1 | Latch enable |
| oe | input | 1 | Output enable |
| pad_in | input | W | Value received from the pad |
| pad_out | output | W | Pad drive value |
| pad_oe | output | W | Per-bit pad drive enable |
| in_data | output | W | Captured pad input |
| adj_out | output | W | Multiplexer result for a neighbouring cell |

## Verification
The bench walks all combinations of output mode, input mode, inversion and output stage, drawing random select codes, tie-high masks, enables and data. A wrong select decode or a swapped select bit would show the wrong source on `adj_out`. A register that ignored `ce`, or a latch that kept loading with `en` low, would let the pad value drift while it should hold. The bench also scrambles the configuration pins on every cycle outside reset. A cell that read them live would change mode in mid-run. In open-drain mode it checks that a high data bit releases the pin and is never driven, and that a low bit is driven only while `oe` is set. After each reset it checks that both holding elements read back zero (seen through the inverter).

// File: rtl/mio_pkg.sv
package mio_pkg;

    typedef enum logic [1:0] {
        MODE_PASS     = 2'b00,
        MODE_FLOP     = 2'b01,
        MODE_LATCH    = 2'b10,
        MODE_PASS_ALT = 2'b11
    } hold_mode_e;

    typedef struct packed {
        hold_mode_e out_mode;
        hold_mode_e in_mode;
        logic       invert;
        logic       open_drain;
        logic [3:0] tie_high;
    } cell_cfg_t;

endpackage

// File: rtl/mio_mux4.sv
module mio_mux4 #(
    parameter int W = 8
) (
    input  logic [3:0][W-1:0] src,
    input  logic [3:0]        tie_high,
    input  logic [1:0]        sel,
    output logic [W-1:0]      y
);
    localparam int NSRC = 4;

    logic [NSRC-1:0][W-1:0] eff;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assign eff[k] = tie_high[k] ? {W{1'b1}} : src[k];
    end

    always_comb begin
        y = eff[sel];
    end
endmodule

// File: rtl/mio_hold.sv
module mio_hold
    import mio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  hold_mode_e   mode,
    input  logic         ce,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.val = '0;
        end else if ((mode == MODE_FLOP && ce) || (mode == MODE_LATCH && en)) begin
            st_d.val = d;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        unique case (mode)
            MODE_FLOP:  q = st_q.val;
            MODE_LATCH: q = en ? d : st_q.val;
            default:    q = d;
        endcase
    end
endmodule

// File: rtl/mio_pad_drive.sv
module mio_pad_drive #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    input  logic         invert,
    input  logic         open_drain,
    input  logic         oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    logic [W-1:0] pol;

    always_comb begin
        pol = data ^ {W{invert}};
        if (open_drain) begin
            pad_out = '0;
            pad_oe  = oe ? ~pol : '0;
        end else begin
            pad_out = pol;
            pad_oe  = {W{oe}};
        end
    end
endmodule

// File: rtl/mux_io_cell.sv
module mux_io_cell
    import mio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   cfg_out_mode,
    input  logic [1:0]   cfg_in_mode,
    input  logic         cfg_invert,
    input  logic         cfg_open_drain,
    input  logic [3:0]   cfg_tie_high,
    input  logic [W-1:0] src0,
    input  logic [W-1:0] src1,
    input  logic [W-1:0] src2,
    input  logic [W-1:0] src3,
    input  logic [1:0]   sel,
    input  logic         ce,
    input  logic         en,
    input  logic         oe,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] in_data,
    output logic [W-1:0] adj_out
);
    cell_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (rst) begin
            cfg_d.out_mode   = hold_mode_e'(cfg_out_mode);
            cfg_d.in_mode    = hold_mode_e'(cfg_in_mode);
            cfg_d.invert     = cfg_invert;
            cfg_d.open_drain = cfg_open_drain;
            cfg_d.tie_high   = cfg_tie_high;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    logic [3:0][W-1:0] src_bus;
    logic [W-1:0]      mux_w;
    logic [W-1:0]      stored_w;

    assign src_bus = {src3, src2, src1, src0};

    mio_mux4 #(.W(W)) i_mux (
        .src      (src_bus),
        .tie_high (cfg_q.tie_high),
        .sel      (sel),
        .y        (mux_w)
    );

    mio_hold #(.W(W)) i_out_hold (
        .clk  (clk),
        .rst  (rst),
        .mode (cfg_q.out_mode),
        .ce   (ce),
        .en   (en),
        .d    (mux_w),
        .q    (stored_w)
    );

    mio_hold #(.W(W)) i_in_hold (
        .clk  (clk),
        .rst  (rst),
        .mode (cfg_q.in_mode),
        .ce   (ce),
        .en   (en),
        .d    (pad_in),
        .q    (in_data)
    );

    mio_pad_drive #(.W(W)) i_drive (
        .data       (stored_w),
        .invert     (cfg_q.invert),
        .open_drain (cfg_q.open_drain),
        .oe         (oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    assign adj_out = mux_w;
endmodule

// File: rtl/mio_checker.sv
module mio_checker
    import mio_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input cell_cfg_t    cfg_q,
    input logic         ce,
    input logic         en,
    input logic         oe,
    input logic [W-1:0] mux_w,
    input logic [W-1:0] stored_w,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe
);
    AST_FLOP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.out_mode == MODE_FLOP && ce) |=> (stored_w == $past(mux_w))); // R3

    AST_FLOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.out_mode == MODE_FLOP && !ce) |=> $stable(stored_w)); // R3

    AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.out_mode == MODE_LATCH && en) |-> (stored_w == mux_w)); // R4

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.out_mode == MODE_LATCH && !en ##1 !en) |-> $stable(stored_w)); // R4

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !oe |-> (pad_oe == '0)); // R7

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
        cfg_q.open_drain |-> (pad_out == '0)); // R8
endmodule

bind mux_io_cell mio_checker #(.W(W)) i_checker (
    .clk      (clk),
    .rst      (rst),
    .cfg_q    (cfg_q),
    .ce       (ce),
    .en       (en),
    .oe       (oe),
    .mux_w    (mux_w),
    .stored_w (stored_w),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
);

// File: tb/test_mux_io_cell.sv
`timescale 1ns/1ps
module test_mux_io_cell;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   cfg_out_mode = '0, cfg_in_mode = '0;
    logic         cfg_invert = 1'b0, cfg_open_drain = 1'b0;
    logic [3:0]   cfg_tie_high = '0;
    logic [W-1:0] src0 = '0, src1 = '0, src2 = '0, src3 = '0, pad_in = '0;
    logic [1:0]   sel = '0;
    logic         ce = 1'b0, en = 1'b0, oe = 1'b0;
    logic [W-1:0] pad_out, pad_oe, in_data, adj_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench-side copy of the configuration and holding state
    logic [1:0] m_out, m_in;
    logic       m_inv, m_od;
    logic [3:0] m_tie;
    logic [W-1:0] m_oq, m_iq;
    int fix_ce = -1;

    always #10 clk = ~clk;

    mux_io_cell #(.W(W)) i_mux_io_cell (.*);

    function automatic logic [W-1:0] f_mux();
        logic [W-1:0] v;
        case (sel)
            2'd0: v = src0;
            2'd1: v = src1;
            2'd2: v = src2;
            default: v = src3;
        endcase
        if (m_tie[sel]) v = '1;
        return v;
    endfunction

    function automatic logic [W-1:0] f_hold(logic [1:0] mode, logic [W-1:0] d, logic [W-1:0] q);
        if (mode == 2'b01) return q;
        if (mode == 2'b10) return en ? d : q;
        return d;
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(string reset_tag);
        logic [W-1:0] mx, st, pol, eo, eoe;
        string t;
        mx  = f_mux();
        st  = f_hold(m_out, mx, m_oq);
        pol = st ^ {W{m_inv}};
        chk(m_tie[sel] ? "R2 adj tie" : "R1/R11 adj select", adj_out, mx);
        t = (m_out == 2'b01) ? "R3" : (m_out == 2'b10) ? "R4" : "R5";
        if (m_inv) t = {t, "/R6"};
        if (reset_tag != "") t = reset_tag;
        if (m_od) begin
            eo  = '0;
            eoe = oe ? ~pol : '0;
            chk({t, " R8 od out"}, pad_out, eo);
            chk({t, " R8 od oe"}, pad_oe, eoe);
        end else begin
            chk({t, " R7 data"}, pad_out, pol);
            chk("R7 oe", pad_oe, {W{oe}});
        end
        chk(reset_tag != "" ? reset_tag : "R9 in_data", in_data, f_hold(m_in, pad_in, m_iq));
    endtask

    task automatic step(string reset_tag);
        sel    = 2'($urandom);
        src0   = W'($urandom); src1 = W'($urandom);
        src2   = W'($urandom); src3 = W'($urandom);
        pad_in = W'($urandom);
        ce = (fix_ce < 0) ? 1'($urandom) : 1'(fix_ce);
        en = (fix_ce < 0) ? (($urandom % 3) == 0) : 1'b0;
        oe = ($urandom % 4) != 0;
        // R10: configuration pins move freely outside reset and must be ignored
        cfg_out_mode = 2'($urandom); cfg_in_mode = 2'($urandom);
        cfg_invert = 1'($urandom); cfg_open_drain = 1'($urandom);
        cfg_tie_high = 4'($urandom);
        #2;
        check_outputs(reset_tag);
        @(posedge clk);
        if ((m_out == 2'b01 && ce) || (m_out == 2'b10 && en)) m_oq = f_mux();
        if ((m_in  == 2'b01 && ce) || (m_in  == 2'b10 && en)) m_iq = pad_in;
        @(negedge clk);
    endtask

    task automatic do_config(logic [1:0] om, logic [1:0] im, logic iv, logic od, logic [3:0] tie);
        @(negedge clk);
        rst = 1'b1;
        cfg_out_mode = om; cfg_in_mode = im;
        cfg_invert = iv; cfg_open_drain = od; cfg_tie_high = tie;
        repeat (2) @(posedge clk);
        m_out = om; m_in = im; m_inv = iv; m_od = od; m_tie = tie;
        m_oq = '0; m_iq = '0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        // R10: reset state seen through register mode with enable held off
        do_config(2'b01, 2'b01, 1'b1, 1'b0, 4'h0);
        fix_ce = 0;
        step("R10 reset state");
        step("R10 reset state");
        fix_ce = -1;
        do_config(2'b10, 2'b10, 1'b0, 1'b1, 4'h0);
        fix_ce = 0;
        step("R10 reset latch");
        fix_ce = -1;
        // exhaustive mode sweep with random traffic
        for (int om = 0; om < 4; om++)
            for (int im = 0; im < 4; im++)
                for (int iv = 0; iv < 2; iv++)
                    for (int od = 0; od < 2; od++) begin
                        do_config(2'(om), 2'(im), 1'(iv), 1'(od), 4'($urandom));
                        for (int n = 0; n < 30; n++) step("");
                    end
        // directed: every select code with all inputs tied high, then none
        do_config(2'b00, 2'b00, 1'b0, 1'b0, 4'hf);
        for (int n = 0; n < 8; n++) step("");
        do_config(2'b00, 2'b00, 1'b0, 1'b0, 4'h0);
        for (int n = 0; n < 8; n++) step("");
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule